// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Status

This block receives characters from an asynchronous serial line. It is driven by a clock enable that pulses sixteen times per bit period. It finds the falling edge of a start bit and confirms that bit at its midpoint. It then samples each data bit, the optional parity bit and the first stop bit at the middle of its bit period. Every completed character goes into a receive buffer register, and a one-cycle completion pulse marks its arrival.

A status byte reports how the most recent character was received. It has three flags, one each for a parity mismatch, a missing stop bit and an unread buffer that was overwritten. Each new character replaces all three flags. The overrun condition comes back on every further character until the host reads the buffer, which it signals with a one-cycle read strobe.

Mode inputs choose the character length (7 or 8 data bits), the parity rule (none, forced zero, even or odd) and one or two stop bits. Baud-rate generation, transmission, interrupt routing and bus decoding are left to neighbouring blocks.

Top module: `uart_rx_stat`

## Requirements
- R1: After reset `rx_status` reads 0x00, and bits 7 to 3 of `rx_status` read 0 at all times. Bit 2 is the parity error flag, bit 1 the framing error flag and bit 0 the overrun error flag.
- R2: Data bits arrive least significant bit first. `cfg_len8`=1 selects 8 data bits. `cfg_len8`=0 selects 7, and bit 7 of `rx_data` then reads 0. Each completed character is written to `rx_data`, and `rx_done` is high for exactly one cycle, in the same cycle that `rx_data` and `rx_status` take the character's values.
- R3: `cfg_par` encodes the parity mode as follows: 00 = none (no parity bit on the line), 01 = zero (the bit must be 0), 10 = even (data plus parity bit hold an even number of ones), 11 = odd. The parity flag is set when the received parity bit differs from this rule. With mode none it is always 0.
- R4: The framing flag is set when the first stop bit is sampled low at its midpoint.
- R5: With `cfg_stop2`=1 the second stop bit is never tested. The line is ignored until the end of that bit, so a low second stop bit sets no flag and starts no character.
- R6: When a character completes while the buffer holds an unread character, the overrun flag is set and the new character replaces the buffer contents.
- R7: The overrun flag is set again on every further completed character until `rd_stb` is pulsed. After a read, the next character reports no overrun.
- R8: A `rd_stb` in the same cycle that a character completes counts as a read of the old contents. That character reports no overrun, and the buffer is left holding the new, unread character.
- R9: Each completed character writes all three flags with its own error status, so an earlier error is not kept. The flags change at no other time.
- R10: A falling edge whose start bit reads high at mid-bit is discarded: no `rx_done`, and no change to `rx_data` or `rx_status`.
- R11: Sampling advances only on cycles where `os_tick` is high, 16 ticks per bit. Reception is correct when the ticks are spaced more than one clock apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit period |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_len8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| cfg_par | input | 2 | Parity mode: 00 none, 01 zero, 10 even, 11 odd |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| rd_stb | input | 1 | One-cycle read of the receive buffer |
| rx_data | output | 8 | Receive buffer contents |
| rx_done | output | 1 | One-cycle pulse on character completion |
| rx_status | output | 8 | Error status byte |

## Verification
A buffer read and the completion of a new character can arrive in the same clock cycle. That collision decides whether an overrun is reported and whether the buffer stays marked as full. The bench first times a calibration frame to find the exact cycle in which `rx_done` rises. It then replays the same frame with `rd_stb` placed in that cycle. The result is judged twice: the colliding character must report no overrun, and a following unread character must report one, which shows the buffer was left full.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OS = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    input  logic          len8,
    input  logic [1:0]    par_sel,
    input  logic          stop2,
    output logic          frm_done,
    output logic [DW-1:0] frm_data,
    output logic          frm_perr,
    output logic          frm_ferr
);
    localparam int HALF = OS / 2;
    localparam int HOLD = OS + OS / 2;
    localparam int CW   = $clog2(HOLD + 1);
    localparam int IW   = $clog2(DW);

    typedef struct packed {
        rx_state_e     state;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [DW-1:0] data;
        logic          par_bit;
        logic          done;
        logic          perr;
        logic          ferr;
    } frm_t;

    frm_t q, d;
    par_mode_e pmode;
    logic      par_on;
    logic [IW-1:0] last_idx;

    function automatic logic exp_parity(par_mode_e m, logic [DW-1:0] v);
        case (m)
            PAR_EVEN: return ^v;
            PAR_ODD:  return ~(^v);
            default:  return 1'b0;
        endcase
    endfunction

    always_comb begin
        pmode    = par_mode_e'(par_sel);
        par_on   = (pmode != PAR_NONE);
        last_idx = len8 ? IW'(DW - 1) : IW'(DW - 2);
        d        = q;
        d.done   = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (tick && !rxd) begin
                    d.state = ST_START;
                    d.cnt   = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (q.cnt == CW'(HALF - 1)) begin
                        d.cnt = '0;
                        if (!rxd) begin
                            d.state = ST_DATA;
                            d.idx   = '0;
                            d.data  = '0;
                        end else begin
                            d.state = ST_IDLE;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (q.cnt == CW'(OS - 1)) begin
                        d.cnt          = '0;
                        d.data[q.idx]  = rxd;
                        if (q.idx == last_idx) begin
                            d.state = par_on ? ST_PAR : ST_STOP;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (tick) begin
                    if (q.cnt == CW'(OS - 1)) begin
                        d.cnt     = '0;
                        d.par_bit = rxd;
                        d.state   = ST_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (q.cnt == CW'(OS - 1)) begin
                        d.cnt   = '0;
                        d.done  = 1'b1;
                        d.ferr  = !rxd;
                        d.perr  = par_on && (q.par_bit != exp_parity(pmode, q.data));
                        d.state = stop2 ? ST_HOLD : ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    if (q.cnt == CW'(HOLD - 1)) begin
                        d.cnt   = '0;
                        d.state = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign frm_done = q.done;
    assign frm_data = q.data;
    assign frm_perr = q.perr;
    assign frm_ferr = q.ferr;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |=> !frm_done); // R2

    AST_PE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && par_sel == 2'b00 && $stable(par_sel)) |-> !frm_perr); // R3

    AST_GLITCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_START && tick && q.cnt == CW'(HALF - 1) && rxd)
        |=> (q.state == ST_IDLE && !frm_done)); // R10

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_HOLD) |=> !frm_done); // R5

endmodule

// File: rtl/uart_rx_bufstat.sv
module uart_rx_bufstat #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm_done,
    input  logic [DW-1:0] frm_data,
    input  logic          frm_perr,
    input  logic          frm_ferr,
    input  logic          rd_stb,
    output logic [DW-1:0] buf_data,
    output logic          buf_done,
    output logic [2:0]    stat_flags
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          full;
        logic          done;
        logic          pe;
        logic          fe;
        logic          ove;
    } bs_t;

    bs_t q, d;

    always_comb begin
        d      = q;
        d.done = frm_done;
        if (rd_stb) begin
            d.full = 1'b0;
        end
        if (frm_done) begin
            d.data = frm_data;
            d.full = 1'b1;
            d.pe   = frm_perr;
            d.fe   = frm_ferr;
            d.ove  = q.full && !rd_stb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign buf_data   = q.data;
    assign buf_done   = q.done;
    assign stat_flags = {q.pe, q.fe, q.ove};

    AST_FLAGS_ONLY_ON_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_done |=> $stable(stat_flags)); // R9

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && q.full && !rd_stb) |=> stat_flags[0]); // R6

    AST_FULL_AFTER_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |=> q.full); // R8

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !frm_done) |=> !q.full); // R7

endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat #(
    parameter int OS = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          rxd,
    input  logic          cfg_len8,
    input  logic [1:0]    cfg_par,
    input  logic          cfg_stop2,
    input  logic          rd_stb,
    output logic [DW-1:0] rx_data,
    output logic          rx_done,
    output logic [7:0]    rx_status
);
    logic          f_done;
    logic [DW-1:0] f_data;
    logic          f_perr;
    logic          f_ferr;
    logic [2:0]    flags;

    uart_rx_frame #(.OS(OS), .DW(DW)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (os_tick),
        .rxd      (rxd),
        .len8     (cfg_len8),
        .par_sel  (cfg_par),
        .stop2    (cfg_stop2),
        .frm_done (f_done),
        .frm_data (f_data),
        .frm_perr (f_perr),
        .frm_ferr (f_ferr)
    );

    uart_rx_bufstat #(.DW(DW)) u_bufstat (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_done   (f_done),
        .frm_data   (f_data),
        .frm_perr   (f_perr),
        .frm_ferr   (f_ferr),
        .rd_stb     (rd_stb),
        .buf_data   (rx_data),
        .buf_done   (rx_done),
        .stat_flags (flags)
    );

    assign rx_status = {5'b00000, flags};

    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rx_status[7:3] == 5'b00000); // R1

    AST_DONE_WITH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_status != $past(rx_status)) |-> rx_done); // R2

endmodule

// File: tb/uart_rx_stat_tb.sv
module uart_rx_stat_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       rxd = 1'b1;
    logic       cfg_len8 = 1'b1;
    logic [1:0] cfg_par = 2'b00;
    logic       cfg_stop2 = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rx_data;
    logic       rx_done;
    logic [7:0] rx_status;

    int checks = 0;
    int fails = 0;
    int tpt = 1;
    int done_cnt = 0;
    int cyc = 0;
    int last_done_cyc = 0;
    logic full_m = 1'b0;
    logic tick_ph = 1'b0;

    always #2 clk = ~clk;

    uart_rx_stat u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rxd       (rxd),
        .cfg_len8  (cfg_len8),
        .cfg_par   (cfg_par),
        .cfg_stop2 (cfg_stop2),
        .rd_stb    (rd_stb),
        .rx_data   (rx_data),
        .rx_done   (rx_done),
        .rx_status (rx_status)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rx_done) begin
            done_cnt      <= done_cnt + 1;
            last_done_cyc <= cyc;
        end
        tick_ph <= ~tick_ph;
        os_tick <= (tpt == 1) ? 1'b1 : ~tick_ph;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(logic b, int len16);
        rxd = b;
        repeat (len16 * tpt) @(negedge clk);
    endtask

    function automatic logic par_of(logic [1:0] m, logic [7:0] v);
        case (m)
            2'b10:   return ^v;
            2'b11:   return ~(^v);
            default: return 1'b0;
        endcase
    endfunction

    // caller is at a negedge; start bit begins immediately
    task automatic send_frame(logic [7:0] v, logic bad_par, logic bad_stop, logic bad_stop2);
        logic [7:0] ve;
        ve = cfg_len8 ? v : {1'b0, v[6:0]};
        send_bit(1'b0, 16);
        for (int i = 0; i < (cfg_len8 ? 8 : 7); i++) send_bit(ve[i], 16);
        if (cfg_par != 2'b00) send_bit(par_of(cfg_par, ve) ^ bad_par, 16);
        if (bad_stop) begin
            send_bit(1'b0, 12);
            send_bit(1'b1, 4);
        end else begin
            send_bit(1'b1, 16);
        end
        if (cfg_stop2) send_bit(~bad_stop2, 16);
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        full_m = 1'b0;
    endtask

    // sends one character and checks the result at the ports
    task automatic frame_check(string req, logic [7:0] v, logic bad_par, logic bad_stop,
                               logic bad_stop2);
        int c0;
        logic [7:0] exp_d;
        logic [7:0] exp_s;
        c0 = done_cnt;
        send_frame(v, bad_par, bad_stop, bad_stop2);
        send_bit(1'b1, 2);
        exp_d = cfg_len8 ? v : {1'b0, v[6:0]};
        exp_s = {5'b0, (cfg_par != 2'b00) & bad_par, bad_stop, full_m};
        full_m = 1'b1;
        chk({req, " done count"}, done_cnt - c0, 1);
        chk({req, " data"}, {24'b0, rx_data}, {24'b0, exp_d});
        chk({req, " status"}, {24'b0, rx_status}, {24'b0, exp_s});
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 reset status", {24'b0, rx_status}, 0);
        chk("R1 reset done", {31'b0, rx_done}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // sweep: lengths R2, parity modes R3, stop counts R5, errors R4, flag replacement R9
        for (int ln = 0; ln < 2; ln++) begin
            for (int pm = 0; pm < 4; pm++) begin
                for (int sb = 0; sb < 2; sb++) begin
                    cfg_len8  = ln[0];
                    cfg_par   = pm[1:0];
                    cfg_stop2 = sb[0];
                    for (int k = 0; k < 4; k++) begin
                        frame_check("R2 R3 good char", 8'h5A ^ 8'(k * 8'h3D + ln * 8'h81), 1'b0, 1'b0, 1'b0);
                        do_read();
                    end
                    if (pm != 0) begin
                        frame_check("R3 parity mismatch", 8'hC3 ^ 8'(pm), 1'b1, 1'b0, 1'b0);
                        do_read();
                    end else begin
                        frame_check("R3 none keeps PE low", 8'h96, 1'b1, 1'b0, 1'b0);
                        do_read();
                    end
                    frame_check("R4 stop low", 8'h3C, 1'b0, 1'b1, 1'b0);
                    do_read();
                    if (sb == 1) begin
                        frame_check("R5 second stop low", 8'hE1, 1'b0, 1'b0, 1'b1);
                        do_read();
                    end
                    frame_check("R9 flags replaced", 8'h0F, 1'b0, 1'b0, 1'b0);
                    do_read();
                end
            end
        end

        // start glitch R10
        cfg_len8 = 1'b1; cfg_par = 2'b10; cfg_stop2 = 1'b0;
        frame_check("R10 pre", 8'h11, 1'b1, 1'b0, 1'b0);
        begin
            int c0;
            c0 = done_cnt;
            send_bit(1'b0, 4);
            send_bit(1'b1, 40);
            chk("R10 glitch no done", done_cnt - c0, 0);
            chk("R10 glitch status kept", {24'b0, rx_status}, 32'h4);
            chk("R10 glitch data kept", {24'b0, rx_data}, 32'h11);
        end
        do_read();

        // overrun R6 / R7
        cfg_par = 2'b00;
        frame_check("R6 first", 8'hA1, 1'b0, 1'b0, 1'b0);
        frame_check("R6 overrun", 8'hB2, 1'b0, 1'b0, 1'b0);
        frame_check("R7 overrun again", 8'hC3, 1'b0, 1'b1, 1'b0);
        do_read();
        frame_check("R7 cleared by read", 8'hD4, 1'b0, 1'b0, 1'b0);

        // same-cycle read and completion R8; buffer is full here
        begin
            int t0;
            int m;
            t0 = cyc;
            frame_check("R8 calibration", 8'h21, 1'b0, 1'b0, 1'b0);
            m = last_done_cyc - t0;
            do_read();
            frame_check("R8 refill", 8'h32, 1'b0, 1'b0, 1'b0);
            fork
                send_frame(8'h43, 1'b0, 1'b0, 1'b0);
                begin
                    repeat (m - 1) @(negedge clk);
                    rd_stb = 1'b1;
                    @(negedge clk);
                    rd_stb = 1'b0;
                end
            join
            send_bit(1'b1, 2);
            chk("R8 collision no overrun", {24'b0, rx_status}, 0);
            chk("R8 collision data", {24'b0, rx_data}, 32'h43);
            full_m = 1'b1;
            frame_check("R8 buffer stayed full", 8'h54, 1'b0, 1'b0, 1'b0);
            do_read();
        end

        // spaced ticks R11
        tpt = 2;
        send_bit(1'b1, 4);
        cfg_len8 = 1'b0; cfg_par = 2'b11; cfg_stop2 = 1'b1;
        frame_check("R11 slow ticks", 8'h6B, 1'b0, 1'b0, 1'b0);
        do_read();
        frame_check("R11 slow ticks parity", 8'h35, 1'b1, 1'b0, 1'b1);
        do_read();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule